// File: doc/BRIEF.md
# Virtual Output Queue Credit Scheduler

This block pairs the ingress-side admission control of a virtual output queued switch with the egress-side credit arbiter. A source that wants to send a packet to an output port presents it on the enqueue interface with its source number, port number and byte length. The admission check compares the packet against the occupancy counters of that (source, port) queue, and against a shared buffer pool. The packet is either accepted, which raises one outstanding credit request, or dropped, which increments a drop counter.

Each output port has its own arbiter. When a port has exactly one requesting source and is not paused, that source gets a grant in the cycle right after its request is admitted. When several sources wait on the same port, the arbiter serves them in rotating order. A per-port pause input holds back all grants for that port. The requests stay counted while the port is paused, so none is lost. Once the ingress side has sent a granted packet, it returns the buffer through the release interface, and the queue occupancy and pool usage go down.

Top module: `voq_sched`

## Requirements
- R1: After reset, every queue's packet and byte occupancy is zero. The pool usage and the drop count are zero, and no grant is asserted.
- R2: A queue is numbered q = port*N_SRC + src. Its packet count sits at bits q*PKT_W of occ_pkts_o and its byte count at bits q*BYTE_W of occ_bytes_o. An admitted packet adds 1 packet and enq_len_i bytes to its queue. A release on a non-empty queue subtracts 1 packet and rel_len_i bytes.
- R3: An enqueue to a queue already holding PKT_LIM packets is dropped. drop_cnt_o increments by 1 and the occupancy is unchanged.
- R4: An enqueue whose length would raise the queue's bytes above BYTE_LIM is dropped and counted. If it brings the bytes exactly to BYTE_LIM, it is admitted.
- R5: The first RSV_PKTS packets of each queue use that queue's reserved share. Every packet beyond that holds one pool slot, so pool_used_o equals the sum over all queues of max(0, packets - RSV_PKTS).
- R6: A packet that needs a pool slot while pool_used_o equals POOL_PKTS is dropped and counted.
- R7: Each admitted packet produces exactly one grant on its port, and no grant is issued without one. On an idle, unpaused port, gnt_valid_o[port] is high with gnt_src_o = src in the cycle after admission. gnt_src_o for port p sits at bits p*SRC_W.
- R8: While pause_i[p] is high, gnt_valid_o[p] stays low. Pending requests are kept, and the grant appears combinationally once the pause drops.
- R9: A port grants at most one source per cycle. The search starts at the source after the last one granted on that port (source 0 after reset) and wraps around the source numbers.
- R10: An enqueue and a release in the same cycle both take effect. Admission is judged on the counts from before that cycle. A request admitted in the same cycle as a grant to the same queue is kept and granted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Enqueue request strobe |
| enq_src_i | input | SRC_W | Source of the enqueued packet |
| enq_port_i | input | PORT_W | Destination port of the enqueued packet |
| enq_len_i | input | LEN_W | Packet length in bytes |
| rel_valid_i | input | 1 | Buffer release strobe |
| rel_src_i | input | SRC_W | Source of the released packet |
| rel_port_i | input | PORT_W | Port of the released packet |
| rel_len_i | input | LEN_W | Released packet length in bytes |
| pause_i | input | N_PORT | Per-port grant hold |
| gnt_valid_o | output | N_PORT | Per-port grant strobe |
| gnt_src_o | output | N_PORT*SRC_W | Granted source per port |
| occ_pkts_o | output | NQ*PKT_W | Packet occupancy per queue |
| occ_bytes_o | output | NQ*BYTE_W | Byte occupancy per queue |
| pool_used_o | output | POOL_W | Shared pool slots in use |
| drop_cnt_o | output | DROP_W | Dropped packet count |

## Verification
Two pairs of functions can act in the same cycle. One is a queue's request counter taking a new admission in the same cycle that its port grant consumes a request. The bench provokes this by repeating an enqueue to an idle port while the first grant is showing, and judges it by seeing a second grant on the next cycle and none after. The other is an enqueue coinciding with a release. It is tested across queues while the pool is full, where the arriving packet must still be dropped, and within one queue above its reserve, where both the packet and byte counts and the pool usage must come out net-unchanged except for the length difference.

// File: rtl/voq_pkg.sv
package voq_pkg;
  typedef enum logic [2:0] {
    ADM_RSV,
    ADM_POOL,
    ADM_DROP_PKT,
    ADM_DROP_BYTE,
    ADM_DROP_POOL
  } adm_e;

  function automatic int unsigned wrap_add(int unsigned base, int unsigned step, int unsigned n);
    int unsigned t;
    t = base + step;
    return (t >= n) ? t - n : t;
  endfunction
endpackage

// File: rtl/voq_admit_ctl.sv
module voq_admit_ctl
  import voq_pkg::*;
#(
  parameter int PKT_LIM   = 6,
  parameter int BYTE_LIM  = 1000,
  parameter int RSV_PKTS  = 2,
  parameter int POOL_PKTS = 5,
  parameter int PKT_W     = 3,
  parameter int BYTE_W    = 10,
  parameter int POOL_W    = 3,
  parameter int LEN_W     = 10
) (
  input  logic [PKT_W-1:0]  pkts_i,
  input  logic [BYTE_W-1:0] bytes_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [POOL_W-1:0] pool_used_i,
  output adm_e              adm_o
);
  always_comb begin
    if (int'(pkts_i) >= PKT_LIM)                      adm_o = ADM_DROP_PKT;
    else if (int'(bytes_i) + int'(len_i) > BYTE_LIM)  adm_o = ADM_DROP_BYTE;
    else if (int'(pkts_i) < RSV_PKTS)                 adm_o = ADM_RSV;
    else if (int'(pool_used_i) >= POOL_PKTS)          adm_o = ADM_DROP_POOL;
    else                                              adm_o = ADM_POOL;
  end
endmodule

// File: rtl/voq_queue_ctr.sv
module voq_queue_ctr #(
  parameter int PKT_W  = 3,
  parameter int BYTE_W = 10,
  parameter int LEN_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_i,
  input  logic [LEN_W-1:0]  add_len_i,
  input  logic              rel_i,
  input  logic [LEN_W-1:0]  rel_len_i,
  input  logic              take_i,
  output logic [PKT_W-1:0]  pkts_o,
  output logic [BYTE_W-1:0] bytes_o,
  output logic [PKT_W-1:0]  pend_o
);
  logic [BYTE_W-1:0] add_b, rel_b;

  assign add_b = add_i ? BYTE_W'(add_len_i) : '0;
  assign rel_b = rel_i ? BYTE_W'(rel_len_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkts_o  <= '0;
      bytes_o <= '0;
      pend_o  <= '0;
    end else begin
      pkts_o  <= pkts_o + PKT_W'(add_i) - PKT_W'(rel_i);
      bytes_o <= bytes_o + add_b - rel_b;
      // outstanding credit requests, net of same-cycle grant
      pend_o  <= pend_o + PKT_W'(add_i) - PKT_W'(take_i);
    end
  end
endmodule

// File: rtl/voq_rr_arb.sv
module voq_rr_arb
  import voq_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             hold_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int k = 0; k < N; k++) begin
      if (!gnt_valid_o && !hold_i && req_i[wrap_add(int'(ptr_q), k, N)]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IDX_W'(wrap_add(int'(ptr_q), k, N));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_q <= '0;
    else if (gnt_valid_o) ptr_q <= IDX_W'(wrap_add(int'(gnt_idx_o), 1, N));
  end
endmodule

// File: rtl/voq_sched.sv
module voq_sched
  import voq_pkg::*;
#(
  parameter int N_SRC     = 4,
  parameter int N_PORT    = 2,
  parameter int PKT_LIM   = 6,
  parameter int BYTE_LIM  = 1000,
  parameter int RSV_PKTS  = 2,
  parameter int POOL_PKTS = 5,
  parameter int LEN_W     = 10,
  parameter int DROP_W    = 16,
  localparam int SRC_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int PORT_W   = (N_PORT > 1) ? $clog2(N_PORT) : 1,
  localparam int NQ       = N_SRC * N_PORT,
  localparam int PKT_W    = $clog2(PKT_LIM + 1),
  localparam int BYTE_W   = $clog2(BYTE_LIM + 1),
  localparam int POOL_W   = $clog2(POOL_PKTS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enq_valid_i,
  input  logic [SRC_W-1:0]        enq_src_i,
  input  logic [PORT_W-1:0]       enq_port_i,
  input  logic [LEN_W-1:0]        enq_len_i,
  input  logic                    rel_valid_i,
  input  logic [SRC_W-1:0]        rel_src_i,
  input  logic [PORT_W-1:0]       rel_port_i,
  input  logic [LEN_W-1:0]        rel_len_i,
  input  logic [N_PORT-1:0]       pause_i,
  output logic [N_PORT-1:0]       gnt_valid_o,
  output logic [N_PORT*SRC_W-1:0] gnt_src_o,
  output logic [NQ*PKT_W-1:0]     occ_pkts_o,
  output logic [NQ*BYTE_W-1:0]    occ_bytes_o,
  output logic [POOL_W-1:0]       pool_used_o,
  output logic [DROP_W-1:0]       drop_cnt_o
);
  localparam int Q_W = (NQ > 1) ? $clog2(NQ) : 1;

  logic [PKT_W-1:0]  pk_w   [NQ];
  logic [BYTE_W-1:0] by_w   [NQ];
  logic [PKT_W-1:0]  pend_w [NQ];
  logic [NQ-1:0]     add_w, rel_w, take_w, req_w;
  logic [SRC_W-1:0]  gnt_idx [N_PORT];

  logic [Q_W-1:0]    qe, qr;
  logic              enq_in, rel_in, enq_ok, rel_ok, same_q;
  logic [PKT_W-1:0]  enq_pk, rel_pk;
  logic [BYTE_W-1:0] enq_by;
  logic              pool_inc, pool_dec;
  adm_e              adm;

  assign enq_in = (int'(enq_src_i) < N_SRC) && (int'(enq_port_i) < N_PORT);
  assign rel_in = (int'(rel_src_i) < N_SRC) && (int'(rel_port_i) < N_PORT);
  assign qe     = Q_W'(int'(enq_port_i) * N_SRC + int'(enq_src_i));
  assign qr     = Q_W'(int'(rel_port_i) * N_SRC + int'(rel_src_i));
  assign enq_pk = enq_in ? pk_w[qe] : '0;
  assign enq_by = enq_in ? by_w[qe] : '0;
  assign rel_pk = rel_in ? pk_w[qr] : '0;

  voq_admit_ctl #(
    .PKT_LIM(PKT_LIM), .BYTE_LIM(BYTE_LIM), .RSV_PKTS(RSV_PKTS), .POOL_PKTS(POOL_PKTS),
    .PKT_W(PKT_W), .BYTE_W(BYTE_W), .POOL_W(POOL_W), .LEN_W(LEN_W)
  ) i_admit (
    .pkts_i(enq_pk), .bytes_i(enq_by), .len_i(enq_len_i),
    .pool_used_i(pool_used_o), .adm_o(adm)
  );

  assign enq_ok = enq_valid_i && enq_in && (adm == ADM_RSV || adm == ADM_POOL);
  assign rel_ok = rel_valid_i && rel_in && (rel_pk != '0);
  assign same_q = enq_ok && (qe == qr);

  // pool slot freed only if the queue stays above its reserve after this cycle's enqueue
  assign pool_inc = enq_ok && (adm == ADM_POOL);
  assign pool_dec = rel_ok && (int'(rel_pk) + int'(same_q) > RSV_PKTS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pool_used_o <= '0;
      drop_cnt_o  <= '0;
    end else begin
      pool_used_o <= pool_used_o + POOL_W'(pool_inc) - POOL_W'(pool_dec);
      if (enq_valid_i && enq_in && !enq_ok) drop_cnt_o <= drop_cnt_o + 1'b1;
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_q
    localparam int S = g % N_SRC;
    localparam int P = g / N_SRC;

    assign add_w[g]  = enq_ok && (qe == Q_W'(g));
    assign rel_w[g]  = rel_ok && (qr == Q_W'(g));
    assign take_w[g] = gnt_valid_o[P] && (gnt_idx[P] == SRC_W'(S));
    assign req_w[g]  = (pend_w[g] != '0);

    voq_queue_ctr #(.PKT_W(PKT_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) i_ctr (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .add_i(add_w[g]), .add_len_i(enq_len_i),
      .rel_i(rel_w[g]), .rel_len_i(rel_len_i),
      .take_i(take_w[g]),
      .pkts_o(pk_w[g]), .bytes_o(by_w[g]), .pend_o(pend_w[g])
    );

    assign occ_pkts_o[g*PKT_W +: PKT_W]    = pk_w[g];
    assign occ_bytes_o[g*BYTE_W +: BYTE_W] = by_w[g];
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    voq_rr_arb #(.N(N_SRC), .IDX_W(SRC_W)) i_arb (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .req_i(req_w[p*N_SRC +: N_SRC]),
      .hold_i(pause_i[p]),
      .gnt_valid_o(gnt_valid_o[p]),
      .gnt_idx_o(gnt_idx[p])
    );
    assign gnt_src_o[p*SRC_W +: SRC_W] = gnt_idx[p];
  end
endmodule

// File: rtl/voq_sched_chk.sv
module voq_sched_chk #(
  parameter int N_SRC     = 4,
  parameter int N_PORT    = 2,
  parameter int PKT_LIM   = 6,
  parameter int BYTE_LIM  = 1000,
  parameter int RSV_PKTS  = 2,
  parameter int POOL_PKTS = 5,
  parameter int DROP_W    = 16,
  parameter int SRC_W     = 2,
  parameter int NQ        = 8,
  parameter int PKT_W     = 3,
  parameter int BYTE_W    = 10,
  parameter int POOL_W    = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_PORT-1:0]       pause_i,
  input logic [N_PORT-1:0]       gnt_valid_o,
  input logic [N_PORT*SRC_W-1:0] gnt_src_o,
  input logic [NQ*PKT_W-1:0]     occ_pkts_o,
  input logic [NQ*BYTE_W-1:0]    occ_bytes_o,
  input logic [POOL_W-1:0]       pool_used_o,
  input logic [DROP_W-1:0]       drop_cnt_o
);
  int pool_sum;
  always_comb begin
    pool_sum = 0;
    for (int q = 0; q < NQ; q++)
      if (int'(occ_pkts_o[q*PKT_W +: PKT_W]) > RSV_PKTS)
        pool_sum += int'(occ_pkts_o[q*PKT_W +: PKT_W]) - RSV_PKTS;
  end

  AST_POOL_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pool_used_o) == pool_sum); // R5

  AST_POOL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pool_used_o) <= POOL_PKTS); // R6

  AST_DROP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (drop_cnt_o == $past(drop_cnt_o) || drop_cnt_o == DROP_W'($past(drop_cnt_o) + 1'b1))); // R3

  for (genvar q = 0; q < NQ; q++) begin : g_q
    AST_PKT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(occ_pkts_o[q*PKT_W +: PKT_W]) <= PKT_LIM); // R3
    AST_BYTE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(occ_bytes_o[q*BYTE_W +: BYTE_W]) <= BYTE_LIM); // R4
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_p
    logic [PKT_W-1:0] gnt_occ;
    assign gnt_occ = occ_pkts_o[(p*N_SRC + int'(gnt_src_o[p*SRC_W +: SRC_W]))*PKT_W +: PKT_W];

    AST_PAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pause_i[p] |-> !gnt_valid_o[p]); // R8
    AST_GNT_OCCUPIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_valid_o[p] |-> gnt_occ != '0); // R7
  end
endmodule

bind voq_sched voq_sched_chk #(
  .N_SRC(N_SRC), .N_PORT(N_PORT), .PKT_LIM(PKT_LIM), .BYTE_LIM(BYTE_LIM),
  .RSV_PKTS(RSV_PKTS), .POOL_PKTS(POOL_PKTS), .DROP_W(DROP_W),
  .SRC_W(SRC_W), .NQ(NQ), .PKT_W(PKT_W), .BYTE_W(BYTE_W), .POOL_W(POOL_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pause_i(pause_i),
  .gnt_valid_o(gnt_valid_o), .gnt_src_o(gnt_src_o),
  .occ_pkts_o(occ_pkts_o), .occ_bytes_o(occ_bytes_o),
  .pool_used_o(pool_used_o), .drop_cnt_o(drop_cnt_o)
);

// File: tb/test_voq_sched.sv
module test_voq_sched;
  localparam int N_SRC = 4, N_PORT = 2, PKT_LIM = 6, BYTE_LIM = 1000;
  localparam int RSV = 2, POOL = 5, LEN_W = 10, DROP_W = 16;
  localparam int SRC_W = 2, PORT_W = 1, NQ = 8, PKT_W = 3, BYTE_W = 10, POOL_W = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic enq_valid = 1'b0, rel_valid = 1'b0;
  logic [SRC_W-1:0] enq_src = '0, rel_src = '0;
  logic [PORT_W-1:0] enq_port = '0, rel_port = '0;
  logic [LEN_W-1:0] enq_len = '0, rel_len = '0;
  logic [N_PORT-1:0] pause = '0;
  logic [N_PORT-1:0] gnt_valid;
  logic [N_PORT*SRC_W-1:0] gnt_src;
  logic [NQ*PKT_W-1:0] occ_pkts;
  logic [NQ*BYTE_W-1:0] occ_bytes;
  logic [POOL_W-1:0] pool_used;
  logic [DROP_W-1:0] drop_cnt;

  int nchk = 0, nerr = 0;
  int m_pk [NQ];
  int m_by [NQ];
  int m_drop = 0;

  always #5 clk = ~clk;

  voq_sched i_voq_sched (
    .clk_i(clk), .rst_ni(rst_ni),
    .enq_valid_i(enq_valid), .enq_src_i(enq_src), .enq_port_i(enq_port), .enq_len_i(enq_len),
    .rel_valid_i(rel_valid), .rel_src_i(rel_src), .rel_port_i(rel_port), .rel_len_i(rel_len),
    .pause_i(pause), .gnt_valid_o(gnt_valid), .gnt_src_o(gnt_src),
    .occ_pkts_o(occ_pkts), .occ_bytes_o(occ_bytes),
    .pool_used_o(pool_used), .drop_cnt_o(drop_cnt)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int qid(int s, int p);
    return p * N_SRC + s;
  endfunction

  function automatic int exp_pool();
    int t = 0;
    for (int q = 0; q < NQ; q++) if (m_pk[q] > RSV) t += m_pk[q] - RSV;
    return t;
  endfunction

  task automatic chk_state(input string tag);
    for (int q = 0; q < NQ; q++) begin
      chk({tag, " pkts"}, occ_pkts[q*PKT_W +: PKT_W], m_pk[q]);
      chk({tag, " bytes"}, occ_bytes[q*BYTE_W +: BYTE_W], m_by[q]);
    end
    chk({tag, " pool"}, pool_used, exp_pool());
    chk({tag, " drops"}, drop_cnt, m_drop);
  endtask

  task automatic gnt_chk(input string tag, input int p, input int v, input int s);
    chk({tag, " gnt_valid"}, gnt_valid[p], v);
    if (v != 0) chk({tag, " gnt_src"}, gnt_src[p*SRC_W +: SRC_W], s);
  endtask

  // one enqueue cycle; drive at negedge, judge at the next
  task automatic enq_one(input int s, input int p, input int len, input bit ok, input string tag);
    enq_valid = 1'b1; enq_src = SRC_W'(s); enq_port = PORT_W'(p); enq_len = LEN_W'(len);
    @(negedge clk);
    enq_valid = 1'b0;
    if (ok) begin m_pk[qid(s,p)]++; m_by[qid(s,p)] += len; end
    else m_drop++;
    chk_state(tag);
  endtask

  task automatic rel_one(input int s, input int p, input int len);
    rel_valid = 1'b1; rel_src = SRC_W'(s); rel_port = PORT_W'(p); rel_len = LEN_W'(len);
    @(negedge clk);
    rel_valid = 1'b0;
    m_pk[qid(s,p)]--; m_by[qid(s,p)] -= len;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int ngr;
    for (int q = 0; q < NQ; q++) begin m_pk[q] = 0; m_by[q] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_state("R1");
    for (int p = 0; p < N_PORT; p++) gnt_chk("R1", p, 0, 0);

    // R7 R2: sweep every queue, immediate grant and release
    for (int p = 0; p < N_PORT; p++) begin
      for (int s = 0; s < N_SRC; s++) begin
        enq_valid = 1'b1; enq_src = SRC_W'(s); enq_port = PORT_W'(p); enq_len = LEN_W'(50 + s*10 + p);
        @(negedge clk);
        enq_valid = 1'b0;
        m_pk[qid(s,p)]++; m_by[qid(s,p)] += 50 + s*10 + p;
        gnt_chk("R7 immediate", p, 1, s);
        chk_state("R2 admit");
        @(negedge clk);
        gnt_chk("R7 single grant", p, 0, 0);
        rel_one(s, p, 50 + s*10 + p);
        chk_state("R2 release");
      end
    end

    // R8 R9: paused port collects four requests, then rotates
    pause[1] = 1'b1;
    for (int s = 0; s < N_SRC; s++) begin
      enq_one(s, 1, 10, 1'b1, "R2 paused fill");
      gnt_chk("R8 paused", 1, 0, 0);
    end
    pause[1] = 1'b0;
    #1;
    gnt_chk("R8 release", 1, 1, 0);
    for (int s = 1; s < N_SRC; s++) begin
      @(negedge clk);
      gnt_chk("R9 rotate", 1, 1, s);
    end
    @(negedge clk);
    gnt_chk("R9 drained", 1, 0, 0);
    for (int s = 0; s < N_SRC; s++) rel_one(s, 1, 10);
    chk_state("R2 drained");

    // R9: uneven requests 0,0,2 served 0,2,0
    pause[1] = 1'b1;
    enq_one(0, 1, 10, 1'b1, "R2");
    enq_one(0, 1, 10, 1'b1, "R2");
    enq_one(2, 1, 10, 1'b1, "R2");
    pause[1] = 1'b0;
    #1;
    gnt_chk("R9 first", 1, 1, 0);
    @(negedge clk); gnt_chk("R9 skip idle", 1, 1, 2);
    @(negedge clk); gnt_chk("R9 wrap", 1, 1, 0);
    @(negedge clk); gnt_chk("R9 done", 1, 0, 0);
    rel_one(0, 1, 10); rel_one(0, 1, 10); rel_one(2, 1, 10);

    // R3..R6 admission limits on paused port 0
    pause[0] = 1'b1;
    for (int i = 0; i < PKT_LIM; i++) enq_one(3, 0, 100, 1'b1, "R5 fill");
    enq_one(3, 0, 100, 1'b0, "R3 pkt limit");
    enq_one(2, 0, 600, 1'b1, "R4");
    enq_one(2, 0, 500, 1'b0, "R4 byte over");
    enq_one(2, 0, 400, 1'b1, "R4 byte exact");
    for (int i = 0; i < 3; i++) enq_one(0, 0, 10, 1'b1, "R5 pool use");
    enq_one(1, 0, 10, 1'b1, "R5 reserved");
    enq_one(1, 0, 10, 1'b1, "R5 reserved");
    enq_one(1, 0, 10, 1'b0, "R6 pool full");
    gnt_chk("R8 port0 paused", 0, 0, 0);

    // R10: release on other queue same cycle as enqueue while pool full
    rel_valid = 1'b1; rel_src = 2'd3; rel_port = 1'b0; rel_len = 10'd100;
    enq_valid = 1'b1; enq_src = 2'd1; enq_port = 1'b0; enq_len = 10'd10;
    @(negedge clk);
    rel_valid = 1'b0; enq_valid = 1'b0;
    m_pk[qid(3,0)]--; m_by[qid(3,0)] -= 100; m_drop++;
    chk_state("R10 cross queue");

    // R10: same queue above reserve, enqueue and release together
    rel_valid = 1'b1; rel_src = 2'd0; rel_port = 1'b0; rel_len = 10'd10;
    enq_valid = 1'b1; enq_src = 2'd0; enq_port = 1'b0; enq_len = 10'd20;
    @(negedge clk);
    rel_valid = 1'b0; enq_valid = 1'b0;
    m_by[qid(0,0)] += 10;
    chk_state("R10 same queue");

    // R7: every admitted packet on port 0 yields one grant (6+2+3+2+1)
    pause[0] = 1'b0;
    ngr = 0;
    #1;
    if (gnt_valid[0]) ngr++;
    for (int i = 0; i < 29; i++) begin
      @(negedge clk);
      if (gnt_valid[0]) ngr++;
    end
    chk("R7 grant count", ngr, 14);

    // R10: request arriving with a grant on the same queue
    enq_valid = 1'b1; enq_src = 2'd1; enq_port = 1'b1; enq_len = 10'd20;
    @(negedge clk);
    gnt_chk("R10 first grant", 1, 1, 1);
    @(negedge clk);
    enq_valid = 1'b0;
    m_pk[qid(1,1)] += 2; m_by[qid(1,1)] += 40;
    gnt_chk("R10 kept request", 1, 1, 1);
    chk_state("R10 occupancy");
    @(negedge clk);
    gnt_chk("R10 no extra grant", 1, 0, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule